// File: doc/BRIEF.md
# Prioritized Trap Entry Controller

This block sits beside a processor pipeline. In every cycle it decides whether control must move to a handler, and when it must, it supplies the entry address. It owns the processor status word, which holds the vector-select bit, a three-deep stack of user-mode and interrupt-enable bits, the cause of the last trap and a per-line interrupt mask. Two kinds of event can start a trap. Synchronous exceptions arrive with a 5-bit code. Sixteen level-sensitive interrupt lines are the other source. The return-from-exception strobe pops the mode/enable stack, but only in kernel mode. When user code issues it, the strobe becomes a privileged-instruction trap.

The pipeline raises request inputs for one cycle. The block registers its decision and shows it on the outputs after the next rising edge. In that cycle `take_trap` pulses and `vec_addr` holds the handler address. The status word is updated at the same edge and can always be read on `psw`. Software changes the status word through a write port, and a write counts only in a cycle that has no trap and no return.

Top module: `trap_dispatch`

## Requirements
- R1: A synchronous active-high reset clears the whole status word (vector bit 0, mask 0, kernel mode, interrupts disabled, cause 0) and holds `take_trap` and `rfe_priv_fault` low.
- R2: Interrupts are level-sensitive. Line n causes a trap only while it is high, mask bit n (psw[n]) is 1 and current enable psw[21] is 1. A line dropped before it is taken leaves no request behind.
- R3: When several enabled lines are pending, the line with the highest number wins, and its number is written to the cause field psw[20:16].
- R4: An exception request wins over any pending interrupt. Its code (16..25; 18 = privileged instruction, 21 = translation miss) goes into psw[20:16].
- R5: The vector base is 0xE0000000 when the vector bit psw[27] is 0 and 0xC0000000 when it is 1. A general entry is base + 4.
- R6: A translation-miss exception (code 21) with a faulting-address MSB of 0 enters at base + 8, in user mode and in kernel mode alike. With MSB 1 it enters at base + 4.
- R7: On trap entry the old pair psw[26:25] (user, enable) takes the previous pair psw[24:23], the previous pair takes the current pair psw[22:21], and the current pair becomes 0,0 (kernel, disabled).
- R8: A return in kernel mode copies the previous pair into the current pair and the old pair into the previous pair. The old pair is unchanged and no trap is taken.
- R9: A return in user mode (psw[22] = 1) does not pop. It takes a trap with cause 18, sets `rfe_priv_fault` with `take_trap`, and shifts the stack as in R7.
- R10: A status write stores wdata[27:0], and psw[31:28] always reads 0. A write is dropped in a cycle that takes a trap or performs a return.
- R11: `take_trap`, `vec_addr` and `rfe_priv_fault` are registered. They appear one cycle after the request cycle, and `take_trap` is high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | Level-sensitive interrupt requests |
| exc_req | input | 1 | Synchronous exception request, one cycle |
| exc_code | input | 5 | Exception code, valid with exc_req |
| fault_va_msb | input | 1 | MSB of the faulting virtual address |
| rfe_strobe | input | 1 | Return-from-exception request |
| sr_we | input | 1 | Status word write enable |
| sr_wdata | input | 32 | Status word write data |
| take_trap | output | 1 | Trap taken in the previous cycle |
| vec_addr | output | 32 | Handler entry address |
| rfe_priv_fault | output | 1 | The trap was a return issued in user mode |
| psw | output | 32 | Current processor status word |

## Verification
The assertions assume that `exc_code` lies in the range 16 to 25 whenever `exc_req` is high. They also assume that the pipeline never raises an exception and a return in the same cycle. The bench only ever drives these legal codes, and each scenario task raises one event class per cycle, except where two classes are combined on purpose to test precedence or write dropping. Interrupt lines are driven as held levels and are released before the stack state is inspected, so that a pending line cannot trigger a second trap without the bench intending it.

// File: rtl/trap_dispatch_pkg.sv
package trap_dispatch_pkg;

  localparam int IRQ_LINES = 16;
  localparam int IDX_W     = $clog2(IRQ_LINES);
  localparam int CAUSE_W   = 5;
  localparam int ADDR_W    = 32;

  localparam logic [CAUSE_W-1:0] EXC_PRIV_INSN = 5'd18;
  localparam logic [CAUSE_W-1:0] EXC_XLAT_MISS = 5'd21;
  localparam logic [CAUSE_W-1:0] EXC_LOW       = 5'd16;
  localparam logic [CAUSE_W-1:0] EXC_HIGH      = 5'd25;

  typedef struct packed {
    logic [3:0]           zero;
    logic                 vec;
    logic                 u_old;
    logic                 i_old;
    logic                 u_prev;
    logic                 i_prev;
    logic                 u_cur;
    logic                 i_cur;
    logic [CAUSE_W-1:0]   cause;
    logic [IRQ_LINES-1:0] mask;
  } psw_t;

endpackage

// File: rtl/trap_irq_prio.sv
module trap_irq_prio
  import trap_dispatch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IRQ_LINES-1:0] lines,
  input  logic [IRQ_LINES-1:0] mask,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx
);

  logic [IRQ_LINES-1:0] req;

  genvar g;
  generate
    for (g = 0; g < IRQ_LINES; g++) begin : g_gate
      assign req[g] = lines[g] & mask[g];
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < IRQ_LINES; i++) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  // R3: the chosen line is pending and no higher line is
  a_r3_highest_wins: assert property (@(posedge clk) disable iff (rst)
    hit |-> (req[idx] && ((req >> idx) == IRQ_LINES'(1))));

  // R2: with no enabled request there is never a grant
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |-> !hit);

endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import trap_dispatch_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ROM_BASE   = 32'hE000_0000,
  parameter logic [ADDR_W-1:0] RAM_BASE   = 32'hC000_0000,
  parameter int                GEN_OFFSET = 4,
  parameter int                MISS_OFFSET = 8
)(
  input  logic              vec_sel,
  input  logic              user_miss,
  output logic [ADDR_W-1:0] entry
);

  localparam logic [ADDR_W-1:0] GEN_OFS  = ADDR_W'(GEN_OFFSET);
  localparam logic [ADDR_W-1:0] MISS_OFS = ADDR_W'(MISS_OFFSET);

  logic [ADDR_W-1:0] base;

  always_comb begin
    base  = vec_sel ? RAM_BASE : ROM_BASE;
    entry = base + (user_miss ? MISS_OFS : GEN_OFS);
  end

endmodule

// File: rtl/trap_psw_reg.sv
module trap_psw_reg
  import trap_dispatch_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               enter,
  input  logic [CAUSE_W-1:0] enter_cause,
  input  logic               pop,
  input  logic               wr,
  input  logic [31:0]        wdata,
  output psw_t               psw_q
);

  psw_t psw_d;

  always_comb begin
    psw_d = psw_q;
    if (enter) begin
      psw_d.u_old  = psw_q.u_prev;
      psw_d.i_old  = psw_q.i_prev;
      psw_d.u_prev = psw_q.u_cur;
      psw_d.i_prev = psw_q.i_cur;
      psw_d.u_cur  = 1'b0;
      psw_d.i_cur  = 1'b0;
      psw_d.cause  = enter_cause;
    end else if (pop) begin
      psw_d.u_cur  = psw_q.u_prev;
      psw_d.i_cur  = psw_q.i_prev;
      psw_d.u_prev = psw_q.u_old;
      psw_d.i_prev = psw_q.i_old;
    end else if (wr) begin
      psw_d      = psw_t'(wdata);
    end
    psw_d.zero = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) psw_q <= '0;
    else     psw_q <= psw_d;
  end

  // R7: entry leaves kernel mode with interrupts off and shifts the stack
  a_r7_entry_shift: assert property (@(posedge clk) disable iff (rst)
    enter |=> (!psw_q.u_cur && !psw_q.i_cur &&
               psw_q.u_prev == $past(psw_q.u_cur) &&
               psw_q.i_old  == $past(psw_q.i_prev)));

  // R8: a pop restores current from previous and keeps old
  a_r8_pop_shift: assert property (@(posedge clk) disable iff (rst)
    (pop && !enter) |=> (psw_q.u_cur == $past(psw_q.u_prev) &&
                         psw_q.i_cur == $past(psw_q.i_prev) &&
                         $stable(psw_q.u_old) && $stable(psw_q.i_old)));

  // R10: the top nibble never holds a one
  a_r10_top_zero: assert property (@(posedge clk) disable iff (rst)
    psw_q.zero == 4'd0);

endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
  import trap_dispatch_pkg::*;
#(
  parameter logic [31:0] ROM_BASE = 32'hE000_0000,
  parameter logic [31:0] RAM_BASE = 32'hC000_0000
)(
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] irq_lines,
  input  logic        exc_req,
  input  logic [4:0]  exc_code,
  input  logic        fault_va_msb,
  input  logic        rfe_strobe,
  input  logic        sr_we,
  input  logic [31:0] sr_wdata,
  output logic        take_trap,
  output logic [31:0] vec_addr,
  output logic        rfe_priv_fault,
  output logic [31:0] psw
);

  psw_t               psw_q;
  logic               irq_hit;
  logic [IDX_W-1:0]   irq_idx;
  logic               trap_now;
  logic               pop_now;
  logic               fault_now;
  logic               user_miss;
  logic [CAUSE_W-1:0] cause_now;
  logic [ADDR_W-1:0]  entry;

  trap_irq_prio u_prio (
    .clk   (clk),
    .rst   (rst),
    .lines (irq_lines),
    .mask  (psw_q.mask),
    .hit   (irq_hit),
    .idx   (irq_idx)
  );

  always_comb begin
    trap_now  = 1'b0;
    pop_now   = 1'b0;
    fault_now = 1'b0;
    user_miss = 1'b0;
    cause_now = '0;
    if (exc_req) begin
      trap_now  = 1'b1;
      cause_now = exc_code;
      user_miss = (exc_code == EXC_XLAT_MISS) && !fault_va_msb;
    end else if (rfe_strobe) begin
      if (psw_q.u_cur) begin
        trap_now  = 1'b1;
        fault_now = 1'b1;
        cause_now = EXC_PRIV_INSN;
      end else begin
        pop_now = 1'b1;
      end
    end else if (irq_hit && psw_q.i_cur) begin
      trap_now  = 1'b1;
      cause_now = CAUSE_W'(irq_idx);
    end
  end

  trap_vector_gen #(
    .ROM_BASE (ROM_BASE),
    .RAM_BASE (RAM_BASE)
  ) u_vec (
    .vec_sel   (psw_q.vec),
    .user_miss (user_miss),
    .entry     (entry)
  );

  trap_psw_reg u_psw (
    .clk         (clk),
    .rst         (rst),
    .enter       (trap_now),
    .enter_cause (cause_now),
    .pop         (pop_now),
    .wr          (sr_we && !rfe_strobe),
    .wdata       (sr_wdata),
    .psw_q       (psw_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_trap      <= 1'b0;
      vec_addr       <= '0;
      rfe_priv_fault <= 1'b0;
    end else begin
      take_trap      <= trap_now;
      rfe_priv_fault <= fault_now;
      if (trap_now) vec_addr <= entry;
    end
  end

  assign psw = psw_q;

  // R4: an exception request always yields a trap carrying its code
  a_r4_exc_first: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> (take_trap && psw_q.cause == $past(exc_code)));

  // R5/R6: every entry address is one of the four legal points
  a_r5_vec_legal: assert property (@(posedge clk) disable iff (rst)
    take_trap |-> (vec_addr == ROM_BASE + 32'd4 || vec_addr == ROM_BASE + 32'd8 ||
                   vec_addr == RAM_BASE + 32'd4 || vec_addr == RAM_BASE + 32'd8));

  // R9: a privilege fault is always a trap with cause 18
  a_r9_fault_is_trap: assert property (@(posedge clk) disable iff (rst)
    rfe_priv_fault |-> (take_trap && psw_q.cause == EXC_PRIV_INSN));

  // R2: with enable off and no exception or return, nothing is taken
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (!exc_req && !rfe_strobe && !psw_q.i_cur) |=> !take_trap);

  // R11: after entry interrupts are off, so a bare level cannot retrigger
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (take_trap && !exc_req && !rfe_strobe) |=> !take_trap);

  // input assumption: legal exception codes only
  a_r4_code_range: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (exc_code >= EXC_LOW && exc_code <= EXC_HIGH));

endmodule

// File: tb/trap_dispatch_test.sv
module trap_dispatch_test;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] irq_lines;
  logic        exc_req;
  logic [4:0]  exc_code;
  logic        fault_va_msb;
  logic        rfe_strobe;
  logic        sr_we;
  logic [31:0] sr_wdata;
  logic        take_trap;
  logic [31:0] vec_addr;
  logic        rfe_priv_fault;
  logic [31:0] psw;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_dispatch uut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .exc_req(exc_req),
    .exc_code(exc_code), .fault_va_msb(fault_va_msb), .rfe_strobe(rfe_strobe),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .take_trap(take_trap),
    .vec_addr(vec_addr), .rfe_priv_fault(rfe_priv_fault), .psw(psw)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    irq_lines = '0; exc_req = 1'b0; exc_code = '0; fault_va_msb = 1'b1;
    rfe_strobe = 1'b0; sr_we = 1'b0; sr_wdata = '0;
  endtask

  // one edge: inputs were set at a negedge, results read at the next negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_psw(input logic [31:0] v);
    idle(); sr_we = 1'b1; sr_wdata = v;
    step(); idle();
  endtask

  task automatic t_reset();
    idle(); rst = 1'b1;
    step(); step();
    rst = 1'b0;
    check("R1 psw", psw, 32'h0);
    check("R1 take_trap", {31'd0, take_trap}, 32'd0);
    check("R1 fault", {31'd0, rfe_priv_fault}, 32'd0);
  endtask

  task automatic t_masking();
    write_psw(32'h0020_FFDF);
    irq_lines = 16'h0020; step();
    check("R2 masked line", {31'd0, take_trap}, 32'd0);
    idle(); write_psw(32'h0000_FFFF);
    irq_lines = 16'h0020; step();
    check("R2 enable off", {31'd0, take_trap}, 32'd0);
    idle(); write_psw(32'h0020_FFFF);
    step();
    check("R2 dropped level leaves nothing", {31'd0, take_trap}, 32'd0);
    irq_lines = 16'h0020; step();
    check("R2 taken", {31'd0, take_trap}, 32'd1);
    check("R2 cause/R7 stack", psw, 32'h0085_FFFF);
    check("R5 rom entry", vec_addr, 32'hE000_0004);
    step();
    check("R11 single pulse", {31'd0, take_trap}, 32'd0);
    idle();
  endtask

  task automatic t_priority();
    write_psw(32'h0020_FFFF);
    irq_lines = 16'h4101; step(); idle();
    check("R3 highest line", {27'd0, psw[20:16]}, 32'd14);
    write_psw(32'h0020_FEFF);
    irq_lines = 16'h0181; step(); idle();
    check("R3 masked higher", {27'd0, psw[20:16]}, 32'd7);
  endtask

  task automatic t_exception();
    write_psw(32'h0020_FFFF);
    irq_lines = 16'h4000; exc_req = 1'b1; exc_code = 5'd20; step(); idle();
    check("R4 exc beats irq", {27'd0, psw[20:16]}, 32'd20);
    check("R4 take", {31'd0, take_trap}, 32'd1);
    check("R11 latency fault low", {31'd0, rfe_priv_fault}, 32'd0);
  endtask

  task automatic t_vectors();
    write_psw(32'h0800_0000);
    exc_req = 1'b1; exc_code = 5'd17; step(); idle();
    check("R5 ram entry", vec_addr, 32'hC000_0004);
    exc_req = 1'b1; exc_code = 5'd21; fault_va_msb = 1'b0; step(); idle();
    check("R6 low miss ram", vec_addr, 32'hC000_0008);
    write_psw(32'h0040_0000);
    exc_req = 1'b1; exc_code = 5'd21; fault_va_msb = 1'b0; step(); idle();
    check("R6 low miss user", vec_addr, 32'hE000_0008);
    exc_req = 1'b1; exc_code = 5'd21; fault_va_msb = 1'b1; step(); idle();
    check("R6 high miss", vec_addr, 32'hE000_0004);
  endtask

  task automatic t_return();
    write_psw(32'h0780_0000);
    rfe_strobe = 1'b1; step(); idle();
    check("R8 pop", psw, 32'h07E0_0000);
    check("R8 no trap", {31'd0, take_trap}, 32'd0);
    rfe_strobe = 1'b1; step(); idle();
    check("R9 fault", {31'd0, rfe_priv_fault}, 32'd1);
    check("R9 take", {31'd0, take_trap}, 32'd1);
    check("R9 psw", psw, 32'h0792_0000);
    check("R9 vector", vec_addr, 32'hE000_0004);
  endtask

  task automatic t_write();
    write_psw(32'hFFFF_0000);
    check("R10 top nibble", psw, 32'h0FFF_0000);
    write_psw(32'h0000_0000);
    exc_req = 1'b1; exc_code = 5'd19; sr_we = 1'b1; sr_wdata = 32'h0800_1234;
    step(); idle();
    check("R10 write dropped on trap", psw, 32'h0013_0000);
    write_psw(32'h0080_0000);
    rfe_strobe = 1'b1; sr_we = 1'b1; sr_wdata = 32'h0000_5555;
    step(); idle();
    check("R10 write dropped on return", psw, 32'h0020_0000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(); rst = 1'b1;
    @(negedge clk);
    t_reset();
    t_masking();
    t_priority();
    t_exception();
    t_vectors();
    t_return();
    t_write();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule